// File: doc/BRIEF.md
# Half-Bridge Gate Drive Sequencer

This block turns one PWM command into the two gate commands of a synchronous buck power stage: a high-side gate and a low-side gate. The PWM level arrives already sorted by external comparators into high, low or mid-window. Two feedback flags report whether each gate has discharged below its turn-off threshold. The sequencer waits for these flags, so the dead time between the gates adapts to the real discharge time instead of a fixed count.

Each change of PWM level first turns off the gate that is on. The other gate is turned on only after the feedback confirms that the first gate is off. If a confirmation never arrives, a watchdog latches a fault. If the PWM level stays in the mid-window for a holdoff time, both gates are turned off until the level becomes valid again. Enable low, or reset, parks both gates off.

All inputs except enable are asynchronous and pass through two-flop synchronizers. Enable is assumed to be synchronous to the clock.

Top module: `hb_gate_seq`

## Requirements
- R1: PWM high (`pwm_hi`=1, `pwm_lo`=0) drops `ls_on` 3 cycles after the level is applied. `hs_on` rises only on the cycle after the synchronized low-side-off flag is seen, which is 3 cycles after `lo_gate_off` rises at the port.
- R2: PWM low (`pwm_hi`=0, `pwm_lo`=1) drops `hs_on` 3 cycles after the level is applied. `ls_on` rises only on the cycle after the synchronized high-side-off flag is seen, which is 3 cycles after `hi_gate_off` rises at the port.
- R3: `hs_on` and `ls_on` are never high in the same cycle.
- R4: A mid-window level (`pwm_hi` equal to `pwm_lo`) held for HOLD consecutive cycles drives both gates low on cycle HOLD+2 after it was applied. Both gates stay low while the level stays mid. HOLD = ceil(HOLDOFF_PS / CLK_PERIOD_PS) with a minimum of 2; the defaults give 42.
- R5: When the level leaves the mid-window, shutdown ends and normal sequencing restarts from the new level.
- R6: `en` low drives `hs_on`, `ls_on` and `fault` low at the next clock edge, and keeps them low for as long as `en` stays low.
- R7: A mid-window level held for fewer than HOLD cycles leaves both gate outputs unchanged.
- R8: A wait for a feedback flag that lasts WAIT_LIMIT cycles raises `fault` exactly WAIT_LIMIT cycles after the wait began. Both gates stay low from then on.
- R9: Once set, `fault` stays set whatever the PWM and feedback inputs do, until `en` goes low.
- R10: After reset or enable, both gates stay off until a valid high or low level is seen. Staying in the mid-window drives no gate.
- R11: A PWM reversal during a wait cancels the pending turn-on. The opposite sequence then starts under the same interlock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Enable, synchronous to clk |
| pwm_hi | input | 1 | Comparator flag: PWM above the upper threshold |
| pwm_lo | input | 1 | Comparator flag: PWM below the lower threshold |
| lo_gate_off | input | 1 | Low-side gate is below its turn-off threshold |
| hi_gate_off | input | 1 | High-side gate-to-source voltage is below its threshold |
| hs_on | output | 1 | High-side gate command |
| ls_on | output | 1 | Low-side gate command |
| fault | output | 1 | Feedback wait timed out; cleared by en low |

## Verification
Inputs are driven on the falling edge and outputs are sampled on the falling edge, after a counted number of rising edges:

| Stimulus | Result | Due after |
|---|---|---|
| PWM level change | Gate that is on turns off | 3 edges |
| Feedback flag rises at the port | Opposite gate turns on | 3 edges |
| Enable low | Gates and fault low | 1 edge |
| Mid-window level | Shutdown | HOLD+2 edges |
| Start of a wait | Fault | WAIT_LIMIT edges |

The directed checks sample on the last cycle before each change and on the cycle of the change, so an off-by-one shifts a result out of its window. A bench feedback model with a programmable delay drives the flags. The random segments last long enough to settle, and each is checked against its expected steady value.

// File: rtl/hb_gate_pkg.sv
// Shared types for the half-bridge gate sequencer.
// Assumes: comparator flags pwm_hi / pwm_lo are mutually exclusive when valid.
package hb_gate_pkg;

    typedef enum logic [1:0] {
        LVL_MID  = 2'd0,
        LVL_LOW  = 2'd1,
        LVL_HIGH = 2'd2
    } lvl_t;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_LS_ON   = 3'd1,
        ST_WAIT_HS = 3'd2,
        ST_HS_ON   = 3'd3,
        ST_WAIT_LS = 3'd4,
        ST_SHUT    = 3'd5,
        ST_FAULT   = 3'd6
    } seq_st_t;

    // Map the two comparator flags onto a level; equal flags mean mid-window.
    function automatic lvl_t classify(input logic hi, input logic lo);
        if (hi && !lo)      return LVL_HIGH;
        else if (lo && !hi) return LVL_LOW;
        else                return LVL_MID;
    endfunction

endpackage

// File: rtl/hb_sync.sv
// Multi-bit flop-chain synchronizer, one chain per bit.
// Assumes: bits are independent; STAGES >= 1; synchronous active-low reset.
module hb_sync #(
    parameter int              W       = 4,
    parameter int              STAGES  = 2,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            // First flop samples the asynchronous input.
            always_ff @(posedge clk) begin
                if (!rst_n) stage[g] <= RST_VAL;
                else        stage[g] <= d;
            end
        end else begin : g_rest
            // Later flops resolve metastability.
            always_ff @(posedge clk) begin
                if (!rst_n) stage[g] <= RST_VAL;
                else        stage[g] <= stage[g-1];
            end
        end
    end

    assign q = stage[STAGES-1];
endmodule

// File: rtl/hb_holdoff.sv
// Counts consecutive mid-window cycles and flags the one that completes the holdoff.
// Assumes: HOLD_CYC >= 2; mid is already synchronized.
module hb_holdoff #(
    parameter int HOLD_CYC = 42
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mid,
    output logic expire
);
    localparam int CW = $clog2(HOLD_CYC);
    localparam logic [CW-1:0] LAST = CW'(HOLD_CYC - 1);

    logic [CW-1:0] cnt;

    // Saturating run-length counter of mid-window cycles; cleared by a valid level.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (!mid)       cnt <= '0;
        else if (cnt != LAST) cnt <= cnt + 1'b1;
    end

    // The HOLD_CYC-th mid observation and every one after it.
    assign expire = mid && (cnt == LAST);
endmodule

// File: rtl/hb_seq_fsm.sv
// Break-before-make sequencer with feedback watchdog.
// Assumes: level and feedback inputs are synchronized; en is synchronous.
// Outputs are registered from the next state, so they change on the same edge as the state.
module hb_seq_fsm
    import hb_gate_pkg::*;
#(
    parameter int WAIT_LIMIT = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  lvl_t lvl,
    input  logic lo_off,
    input  logic hi_off,
    input  logic hold_expire,
    output logic hs_on,
    output logic ls_on,
    output logic fault
);
    localparam int WDW = $clog2(WAIT_LIMIT);
    localparam logic [WDW-1:0] WD_LAST = WDW'(WAIT_LIMIT - 1);

    seq_st_t       st, st_nxt;
    logic [WDW-1:0] wd_cnt;
    logic          in_wait, wd_exp;

    assign in_wait = (st == ST_WAIT_HS) || (st == ST_WAIT_LS);
    assign wd_exp  = in_wait && (wd_cnt == WD_LAST);

    // Next-state selection: enable, fault latch, shutdown, then sequencing.
    always_comb begin
        st_nxt = st;
        if (!en) begin
            st_nxt = ST_IDLE;
        end else if (st == ST_FAULT) begin
            st_nxt = ST_FAULT;
        end else if (hold_expire) begin
            st_nxt = ST_SHUT;
        end else begin
            unique case (st)
                ST_IDLE, ST_SHUT: begin
                    if (lvl == LVL_HIGH)     st_nxt = ST_WAIT_HS;
                    else if (lvl == LVL_LOW) st_nxt = ST_WAIT_LS;
                end
                ST_LS_ON:
                    if (lvl == LVL_HIGH) st_nxt = ST_WAIT_HS;
                ST_HS_ON:
                    if (lvl == LVL_LOW)  st_nxt = ST_WAIT_LS;
                ST_WAIT_HS: begin
                    if (lvl == LVL_LOW)  st_nxt = ST_WAIT_LS;
                    else if (lo_off)     st_nxt = ST_HS_ON;
                    else if (wd_exp)     st_nxt = ST_FAULT;
                end
                ST_WAIT_LS: begin
                    if (lvl == LVL_HIGH) st_nxt = ST_WAIT_HS;
                    else if (hi_off)     st_nxt = ST_LS_ON;
                    else if (wd_exp)     st_nxt = ST_FAULT;
                end
                default: st_nxt = ST_IDLE;
            endcase
        end
    end

    // State and registered gate/fault commands.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st    <= ST_IDLE;
            hs_on <= 1'b0;
            ls_on <= 1'b0;
            fault <= 1'b0;
        end else begin
            st    <= st_nxt;
            hs_on <= (st_nxt == ST_HS_ON);
            ls_on <= (st_nxt == ST_LS_ON);
            fault <= (st_nxt == ST_FAULT);
        end
    end

    // Watchdog: cycles spent in the current wait state.
    always_ff @(posedge clk) begin
        if (!rst_n)                          wd_cnt <= '0;
        else if (!in_wait || st_nxt != st)   wd_cnt <= '0;
        else                                 wd_cnt <= wd_cnt + 1'b1;
    end
endmodule

// File: rtl/hb_gate_seq.sv
// Top: half-bridge gate drive sequencer.
// Synchronizes comparator and feedback flags, times the mid-window holdoff,
// and sequences the two gates with adaptive dead time.
// Assumes: en synchronous to clk; CLK_PERIOD_PS is the clk period.
module hb_gate_seq
    import hb_gate_pkg::*;
#(
    parameter int CLK_PERIOD_PS = 10000,
    parameter int HOLDOFF_PS    = 420000,
    parameter int WAIT_LIMIT    = 64,
    parameter int SYNC_STAGES   = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic pwm_hi,
    input  logic pwm_lo,
    input  logic lo_gate_off,
    input  logic hi_gate_off,
    output logic hs_on,
    output logic ls_on,
    output logic fault
);
    localparam int HOLD_RAW = (HOLDOFF_PS + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS;
    localparam int HOLD_CYC = (HOLD_RAW < 2) ? 2 : HOLD_RAW;

    logic [3:0] raw_in, sync_out;
    logic       pwm_hi_s, pwm_lo_s, fb_lo_s, fb_hi_s;
    lvl_t       lvl_s;
    logic       hold_expire;

    assign raw_in = {pwm_hi, pwm_lo, lo_gate_off, hi_gate_off};

    hb_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b0000)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (raw_in),
        .q    (sync_out)
    );

    assign {pwm_hi_s, pwm_lo_s, fb_lo_s, fb_hi_s} = sync_out;
    assign lvl_s = classify(pwm_hi_s, pwm_lo_s);

    hb_holdoff #(.HOLD_CYC(HOLD_CYC)) u_holdoff (
        .clk   (clk),
        .rst_n (rst_n),
        .mid   (lvl_s == LVL_MID),
        .expire(hold_expire)
    );

    hb_seq_fsm #(.WAIT_LIMIT(WAIT_LIMIT)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (en),
        .lvl        (lvl_s),
        .lo_off     (fb_lo_s),
        .hi_off     (fb_hi_s),
        .hold_expire(hold_expire),
        .hs_on      (hs_on),
        .ls_on      (ls_on),
        .fault      (fault)
    );
endmodule

// File: rtl/hb_gate_seq_chk.sv
// Property checker for hb_gate_seq, attached by bind.
// Watches ports plus the synchronizer and holdoff outputs.
module hb_gate_seq_chk
    import hb_gate_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       en,
    input logic       hs_on,
    input logic       ls_on,
    input logic       fault,
    input logic       lo_off_s,
    input logic       hi_off_s,
    input logic [1:0] lvl_s,
    input logic       hold_expire
);
    // R1: high side rises only after low side confirmed off and commanded off
    a_r1_hs_after_lo_off: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_on) |-> ($past(lo_off_s) && !$past(ls_on)));

    // R2: low side rises only after high side confirmed off and commanded off
    a_r2_ls_after_hi_off: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ls_on) |-> ($past(hi_off_s) && !$past(hs_on)));

    // R3: never both gates on
    a_r3_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_on && ls_on));

    // R4: holdoff completion forces both gates low on the next edge
    a_r4_shutdown: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_expire && lvl_s == LVL_MID) |=> (!hs_on && !ls_on));

    // R6: enable low clears gates and fault at the next edge
    a_r6_disable: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!hs_on && !ls_on && !fault));

    // R9: fault persists while enabled
    a_r9_fault_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (fault && en) |=> fault);

    // R8: gates low while faulted
    a_r8_fault_gates_low: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> (!hs_on && !ls_on));
endmodule

bind hb_gate_seq hb_gate_seq_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en),
    .hs_on      (hs_on),
    .ls_on      (ls_on),
    .fault      (fault),
    .lo_off_s   (fb_lo_s),
    .hi_off_s   (fb_hi_s),
    .lvl_s      (lvl_s),
    .hold_expire(hold_expire)
);

// File: tb/test_hb_gate_seq.sv
// Bench for hb_gate_seq: directed timing corners plus seeded random level segments.
module test_hb_gate_seq;
    localparam int CLK_PERIOD = 10;
    localparam int HOLD       = 42;   // ceil(420000/10000)
    localparam int LIMIT      = 64;
    localparam int L_MID = 0, L_LOW = 1, L_HIGH = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0;
    logic pwm_hi = 1'b0, pwm_lo = 1'b0;
    logic lo_gate_off, hi_gate_off;
    logic hs_on, ls_on, fault;

    logic [15:0] ls_hist = '0, hs_hist = '0;
    int          fb_dly  = 1;
    logic        stuck_lo = 1'b0;
    int          n_chk = 0, n_fail = 0;
    bit          done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // Feedback model: a gate reads as off fb_dly cycles after it was commanded off.
    always @(negedge clk) begin
        ls_hist <= {ls_hist[14:0], ls_on};
        hs_hist <= {hs_hist[14:0], hs_on};
    end
    assign lo_gate_off = stuck_lo ? 1'b0 : !ls_hist[fb_dly-1];
    assign hi_gate_off = !hs_hist[fb_dly-1];

    hb_gate_seq i_hb_gate_seq (
        .clk(clk), .rst_n(rst_n), .en(en),
        .pwm_hi(pwm_hi), .pwm_lo(pwm_lo),
        .lo_gate_off(lo_gate_off), .hi_gate_off(hi_gate_off),
        .hs_on(hs_on), .ls_on(ls_on), .fault(fault)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_lvl(input int l);
        pwm_hi = (l == L_HIGH);
        pwm_lo = (l == L_LOW);
    endtask

    task automatic chk(input string req, input logic [2:0] exp);
        logic [2:0] act;
        act = {hs_on, ls_on, fault};
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual={hs,ls,fault}=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    // Settled {hs,ls,fault} after a segment of level l lasting dur cycles.
    function automatic logic [2:0] exp_settled(input int l, input logic [2:0] prev, input int dur);
        if (l == L_HIGH)   return 3'b100;
        if (l == L_LOW)    return 3'b010;
        if (dur >= HOLD)   return 3'b000;
        return prev;
    endfunction

    initial begin
        logic [2:0] prev;
        int last_l;
        bit bad;
        void'($urandom(32'd20240611));

        // R10: reset state
        set_lvl(L_MID);
        tick(3);
        chk("R10 reset", 3'b000);
        rst_n = 1'b1; en = 1'b1;
        tick(HOLD + 10);
        chk("R10 mid after enable drives no gate", 3'b000);

        // R2: low from idle, hi feedback already off
        set_lvl(L_LOW);
        tick(3); chk("R2 ls still off at +3", 3'b000);
        tick(1); chk("R2 ls on at +4", 3'b010);

        // R1: rising sequence with 1-cycle feedback delay
        set_lvl(L_HIGH);
        tick(3); chk("R1 ls off at +3", 3'b000);
        tick(2); chk("R1 hs waits for feedback at +5", 3'b000);
        tick(1); chk("R1 hs on at +6", 3'b100);

        // R2: falling sequence
        set_lvl(L_LOW);
        tick(2); chk("R2 hs held before +3", 3'b100);
        tick(1); chk("R2 hs off at +3", 3'b000);
        tick(2); chk("R2 ls waits at +5", 3'b000);
        tick(1); chk("R2 ls on at +6", 3'b010);

        // R7: short mid window leaves high side on
        set_lvl(L_HIGH); tick(12);
        set_lvl(L_MID);  tick(HOLD - 1);
        set_lvl(L_HIGH);
        bad = 0;
        for (int i = 0; i < HOLD + 8; i++) begin
            tick(1);
            if (!hs_on || ls_on) bad = 1;
        end
        chk("R7 short mid no effect", bad ? 3'b000 : 3'b100);

        // R4: exact holdoff
        set_lvl(L_MID);
        tick(HOLD + 1); chk("R4 hs held at HOLD+1", 3'b100);
        tick(1);        chk("R4 shutdown at HOLD+2", 3'b000);
        tick(20);       chk("R4 held low in mid", 3'b000);

        // R5: leave shutdown to low
        set_lvl(L_LOW);
        tick(4); chk("R5 resume low", 3'b010);

        // R6: disable
        en = 1'b0;
        tick(1); chk("R6 disable clears gates", 3'b000);
        set_lvl(L_HIGH);
        tick(10); chk("R6 held off while disabled", 3'b000);
        en = 1'b1;
        tick(4); chk("R10 first gate on valid level", 3'b100);

        // R11: reversal cancels pending high-side turn-on
        fb_dly = 8;
        set_lvl(L_LOW); tick(30);
        chk("R11 setup low", 3'b010);
        set_lvl(L_HIGH); tick(4);
        chk("R11 waiting, both off", 3'b000);
        set_lvl(L_LOW);
        bad = 0;
        for (int i = 0; i < 30; i++) begin
            tick(1);
            if (hs_on) bad = 1;
        end
        chk("R11 no hs pulse, back to ls", bad ? 3'b100 : {hs_on, ls_on, fault});
        chk("R11 ls restored", 3'b010);

        // R8: watchdog timeout
        fb_dly = 1; stuck_lo = 1'b1;
        set_lvl(L_HIGH);
        tick(2 + LIMIT); chk("R8 no fault before limit", 3'b000);
        tick(1);         chk("R8 fault at limit", 3'b001);
        // R9: fault sticky
        set_lvl(L_LOW); stuck_lo = 1'b0;
        tick(20); chk("R9 fault persists", 3'b001);
        en = 1'b0;
        tick(1); chk("R9 en low clears fault", 3'b000);
        en = 1'b1;
        tick(5); chk("R9 normal after re-enable", 3'b010);

        // Random segments (R1 R2 R3 R4 R5 R7)
        prev = 3'b010; last_l = L_LOW;
        for (int s = 0; s < 60; s++) begin
            int l, dur;
            fb_dly = 1 + int'($urandom_range(5));
            l = int'($urandom_range(2));
            if (l == L_MID && last_l == L_MID) l = L_HIGH;
            if (l == L_MID)
                dur = ($urandom_range(1) == 0) ? 1 + int'($urandom_range(HOLD - 4))
                                               : HOLD + 5 + int'($urandom_range(15));
            else
                dur = 20 + int'($urandom_range(20));
            set_lvl(l);
            bad = 0;
            for (int i = 0; i < dur; i++) begin
                tick(1);
                if (hs_on && ls_on) bad = 1;
            end
            if (bad) begin
                n_chk++; n_fail++;
                $display("FAIL R3 overlap actual=11 expected=not both on");
            end else n_chk++;
            prev = exp_settled(l, prev, dur);
            chk($sformatf("R4 R5 R7 random seg %0d lvl %0d dur %0d", s, l, dur), prev);
            last_l = l;
        end

        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    // Watchdog for a hung run.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule